// File: doc/BRIEF.md
# Graphics Engine Status and Interrupt Register Unit

This unit is the privileged register set that a host processor uses to supervise a graphics engine. It records five kinds of engine events as status flags: a signal primitive, a finish primitive, horizontal sync, vertical sync and the end of a rectangular-area write. It combines these flags with a programmable mask into one level-sensitive interrupt line for the system interrupt controller. The host acknowledges each flag by writing a one to it. The unit also holds a signal ID register, which takes a masked update from a queued signal entry when the host acknowledges the signal, and a transfer-direction register that also reports an output-path-busy status.

The host reaches the unit over a simple register bus that always accepts. Writes carry byte enables, so byte, halfword, word and doubleword accesses all work: lanes that are not enabled count as zero. Reads complete one cycle after the request. Only the signal ID window and the status word can be read. Every other address reads back the status word, so write-only registers such as the mask do not hold their own read path. A software reset bit in the status word returns the whole privileged state to its initial values in one write.

Top module: `gsr_unit`

## Requirements
- R1: A write to the mask register (byte offset 0x010) stores (value AND 0x1F00) OR 0x6000, after disabled lanes are zeroed. Mask bit 8+n masks status flag n. Out of reset the stored value is 0x7F00, so every event is masked.
- R2: `irq` is high exactly while some status flag n is set and mask bit 8+n is clear. It rises in the cycle after a mask write that clears the mask bit of a pending flag.
- R3: A one-cycle pulse on an event input sets its status flag on the next clock edge. The flags are signal=bit 0, finish=bit 1, hsync=bit 2, vsync=bit 3 and rect-end=bit 4 of the status word. When the mask bit of that flag is clear, `irq` is raised as well.
- R4: A status-word write (byte offset 0x000) with a one in bit 1, 2, 3 or 4 clears that flag, and a zero leaves the flag unchanged. An event in the same cycle takes priority over the clear.
- R5: A finish event sets the finish flag only when the finish-fired state is clear, and every accepted finish event sets that state. Writing one to status bit 1 clears it. Hardware reset clears it, and the software reset action sets it.
- R6: Writing one to status bit 0 acknowledges the signal. If an entry is queued, the signal ID becomes (ID AND NOT qmask) OR (qdata AND qmask) and the signal flag is set. If no entry is queued, the signal flag is cleared. The queue is emptied in both cases, and a new queue strobe overwrites any queued entry.
- R7: Writing one to status bit 9 is a software reset. It clears all flags, the signal ID, the queue, the direction and busy bits, and it restores the mask to 0x7F00. It overrides every other bit in the same write and every event in the same cycle.
- R8: Only lanes whose byte enable is set take part in a write. Status bit 8 (flush) has no effect. The revision field (bits 23:16, parameter) and the ID field (bits 31:24, parameter) of the status word cannot be written.
- R9: A read returns `rsp_valid` with data exactly one cycle later and has no side effect. Byte offset 0x080 returns the signal ID in the low word. Any other address with bit 3 clear returns the status word in the low word, and any address with bit 3 set returns zero.
- R10: A write to the direction register (byte offset 0x040, lane 0) copies data bit 0 to status bit 13. A one also sets the busy status bit 12, which is cleared only by a reset.
- R11: After hardware reset, the flags, the signal ID, the direction and busy bits, `irq` and `rsp_valid` are all zero, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address within the region |
| req_wdata | input | DATA_W | Write data, lane-aligned |
| req_be | input | DATA_W/8 | Write byte enables |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Read data |
| ev_signal | input | 1 | Signal event pulse |
| ev_finish | input | 1 | Finish event pulse |
| ev_hsync | input | 1 | Horizontal sync pulse |
| ev_vsync | input | 1 | Vertical sync pulse |
| ev_rect_end | input | 1 | Rectangular-area write end pulse |
| sq_valid | input | 1 | Signal queue strobe |
| sq_data | input | ID_W | Queued signal ID data |
| sq_mask | input | ID_W | Queued signal ID bit mask |
| irq | output | 1 | Interrupt level to the interrupt controller |

## Verification
Mask writes are tried with full-width data, with the same data limited to lane 0 and then to lane 1, and with a single mask bit. The lane-limited writes tell real byte-enable handling apart from a decoder that ignores the enables, and the single mask bit tells per-flag masking apart from a global enable. Status-word writes are tried with all zeros, with a one in a disabled lane, with a clear that coincides with an event, and with ones only in the read-only and flush fields, which tells write-one-to-clear apart from a plain load. Signal acknowledges are tried with and without a queued entry and after two back-to-back strobes, which shows the masked merge, the clearing of an empty queue and overwrite by the newer entry. Reads go to the signal window, the mask address, an unmapped address and upper-word offsets, which tells mirroring apart from decoding each register.

// File: rtl/gsr_pkg.sv
// Package: shared constants and types for the graphics status register unit.
// Assumes byte addressing with doubleword-aligned registers.
package gsr_pkg;
    localparam int NUM_EV      = 5;
    localparam int B_SIG       = 0;
    localparam int B_FIN       = 1;
    localparam int B_FLUSH     = 8;
    localparam int B_SRST      = 9;
    localparam int B_BUSY      = 12;
    localparam int B_DIR       = 13;
    localparam int OFF_CSR     = 'h000;
    localparam int OFF_IMR     = 'h010;
    localparam int OFF_DIR     = 'h040;
    localparam int OFF_SIG     = 'h080;
    localparam logic [15:0] IMR_KEEP  = 16'h1F00;
    localparam logic [15:0] IMR_FORCE = 16'h6000;
    localparam logic [15:0] IMR_INIT  = 16'h7F00;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CSR,
        SEL_IMR,
        SEL_DIR
    } reg_sel_e;
endpackage

// File: rtl/gsr_decode.sv
// Module: address decode and write-lane masking.
// Assumes writes target whole doublewords; the read window is 16 bytes.
module gsr_decode
    import gsr_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 64
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W/8-1:0] be,
    input  logic [DATA_W-1:0]   wdata,
    output reg_sel_e            wr_sel,
    output logic                rd_sig_win,
    output logic                rd_hi,
    output logic [DATA_W-1:0]   lane_data
);
    localparam int BE_W = DATA_W / 8;
    localparam int DW_W = ADDR_W - 3;
    localparam int WN_W = ADDR_W - 4;

    logic [DW_W-1:0] dword;
    logic [2:0]      unused_addr;

    assign dword       = addr[ADDR_W-1:3];
    assign unused_addr = addr[2:0];

    // Select the written register from the doubleword address.
    always_comb begin
        if (dword == DW_W'(OFF_CSR >> 3))      wr_sel = SEL_CSR;
        else if (dword == DW_W'(OFF_IMR >> 3)) wr_sel = SEL_IMR;
        else if (dword == DW_W'(OFF_DIR >> 3)) wr_sel = SEL_DIR;
        else                                   wr_sel = SEL_NONE;
    end

    assign rd_sig_win = (addr[ADDR_W-1:4] == WN_W'(OFF_SIG >> 4));
    assign rd_hi      = addr[3];

    // Zero every byte lane whose enable is low.
    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        assign lane_data[8*g +: 8] = wdata[8*g +: 8] & {8{be[g]}};
    end
endmodule

// File: rtl/gsr_irq_mask.sv
// Module: interrupt mask storage and interrupt level generation.
// Assumes the flags come from registers; irq is a level of flags and mask.
module gsr_irq_mask
    import gsr_pkg::*;
#(
    parameter int N_EV = NUM_EV
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            imr_wr,
    input  logic            soft_rst,
    input  logic [15:0]     imr_val,
    input  logic [N_EV-1:0] flags,
    output logic            irq
);
    logic [15:0]     imr_q;
    logic [N_EV-1:0] mask;

    // Store the mask with the fixed ones forced and other bits dropped.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) imr_q <= IMR_INIT;
        else if (imr_wr)        imr_q <= (imr_val & IMR_KEEP) | IMR_FORCE;
    end

    assign mask = imr_q[8 +: N_EV];
    assign irq  = |(flags & ~mask);
endmodule

// File: rtl/gsr_sigq.sv
// Module: queued signal entry and signal ID register.
// Assumes the acknowledge is never asserted together with soft reset.
module gsr_sigq #(
    parameter int ID_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_rst,
    input  logic            q_stb,
    input  logic [ID_W-1:0] q_data,
    input  logic [ID_W-1:0] q_mask,
    input  logic            ack,
    output logic            queued,
    output logic [ID_W-1:0] sig_id
);
    logic [ID_W-1:0] data_q;
    logic [ID_W-1:0] mask_q;

    // Hold the newest queued entry; a strobe overwrites an older one.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            queued <= 1'b0;
            data_q <= '0;
            mask_q <= '0;
        end else if (q_stb) begin
            queued <= 1'b1;
            data_q <= q_data;
            mask_q <= q_mask;
        end else if (ack) begin
            queued <= 1'b0;
        end
    end

    // Merge the queued data into the ID on an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)  sig_id <= '0;
        else if (ack && queued)  sig_id <= (sig_id & ~mask_q) | (data_q & mask_q);
    end
endmodule

// File: rtl/gsr_unit.sv
// Module: graphics status and interrupt register unit (top).
// Assumes single-cycle event pulses and a bus that is always ready.
module gsr_unit
    import gsr_pkg::*;
#(
    parameter int          ADDR_W = 13,
    parameter int          DATA_W = 64,
    parameter int          ID_W   = 32,
    parameter logic [7:0]  REV    = 8'h1B,
    parameter logic [7:0]  DEV_ID = 8'h55
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_be,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    input  logic                ev_signal,
    input  logic                ev_finish,
    input  logic                ev_hsync,
    input  logic                ev_vsync,
    input  logic                ev_rect_end,
    input  logic                sq_valid,
    input  logic [ID_W-1:0]     sq_data,
    input  logic [ID_W-1:0]     sq_mask,
    output logic                irq
);
    reg_sel_e              wr_sel;
    logic                  rd_sig_win;
    logic                  rd_hi;
    logic [DATA_W-1:0]     lane;
    logic                  wr_en, rd_en, csr_wr, soft_rst, ack;
    logic [NUM_EV-1:0]     flags_q, flags_nx, ev_eff;
    logic                  fired_q, fired_nx;
    logic                  dir_q, busy_q;
    logic                  sig_queued;
    logic [ID_W-1:0]       sig_id;
    logic [31:0]           csr_word;
    logic                  unused_lane;

    gsr_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .addr       (req_addr),
        .be         (req_be),
        .wdata      (req_wdata),
        .wr_sel     (wr_sel),
        .rd_sig_win (rd_sig_win),
        .rd_hi      (rd_hi),
        .lane_data  (lane)
    );

    assign req_ready   = 1'b1;
    assign wr_en       = req_valid && req_write;
    assign rd_en       = req_valid && !req_write;
    assign csr_wr      = wr_en && (wr_sel == SEL_CSR);
    assign soft_rst    = csr_wr && lane[B_SRST];
    assign ack         = csr_wr && lane[B_SIG] && !soft_rst;
    assign unused_lane = ^{lane[DATA_W-1:16], lane[B_FLUSH]};

    gsr_irq_mask #(.N_EV(NUM_EV)) u_imr (
        .clk      (clk),
        .rst_n    (rst_n),
        .imr_wr   (wr_en && (wr_sel == SEL_IMR)),
        .soft_rst (soft_rst),
        .imr_val  (lane[15:0]),
        .flags    (flags_q),
        .irq      (irq)
    );

    gsr_sigq #(.ID_W(ID_W)) u_sigq (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .q_stb    (sq_valid),
        .q_data   (sq_data),
        .q_mask   (sq_mask),
        .ack      (ack),
        .queued   (sig_queued),
        .sig_id   (sig_id)
    );

    assign ev_eff = {ev_rect_end, ev_vsync, ev_hsync, ev_finish && !fired_q, ev_signal};

    // Next status flags: acknowledge/clear first, then events win, reset overrides.
    always_comb begin
        flags_nx = flags_q;
        fired_nx = fired_q;
        for (int i = 1; i < NUM_EV; i++) begin
            if (csr_wr && lane[i]) flags_nx[i] = 1'b0;
        end
        if (ack)                     flags_nx[B_SIG] = sig_queued;
        if (csr_wr && lane[B_FIN])   fired_nx = 1'b0;
        if (ev_eff[B_FIN])           fired_nx = 1'b1;
        flags_nx = flags_nx | ev_eff;
        if (soft_rst) begin
            flags_nx = '0;
            fired_nx = 1'b1;
        end
    end

    // Register the status flags and the finish-fired state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            fired_q <= 1'b0;
        end else begin
            flags_q <= flags_nx;
            fired_q <= fired_nx;
        end
    end

    // Transfer direction and output-path-busy status.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            dir_q  <= 1'b0;
            busy_q <= 1'b0;
        end else if (wr_en && (wr_sel == SEL_DIR) && req_be[0]) begin
            dir_q <= lane[0];
            if (lane[0]) busy_q <= 1'b1;
        end
    end

    assign csr_word = {DEV_ID, REV, 2'b00, dir_q, busy_q, 7'b0, flags_q};

    // Registered read response with status-word mirroring.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_en;
            if (rd_en) begin
                if (rd_hi)           rsp_rdata <= '0;
                else if (rd_sig_win) rsp_rdata <= DATA_W'(sig_id);
                else                 rsp_rdata <= DATA_W'(csr_word);
            end
        end
    end
endmodule

// Checker: temporal properties of the register unit, bound to the top.
module gsr_unit_chk #(
    parameter int N_EV = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_write,
    input logic            rsp_valid,
    input logic            irq,
    input logic            ev_hsync,
    input logic            ev_vsync,
    input logic            csr_wr,
    input logic            soft_rst,
    input logic            ack,
    input logic            sig_queued,
    input logic [15:0]     lane_lo,
    input logic [N_EV-1:0] flags
);
    a_r9_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);
    a_r9_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);
    a_r3_vsync_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_vsync && !soft_rst) |=> flags[3]);
    a_r4_w1c_hsync: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && lane_lo[2] && !ev_hsync && !soft_rst) |=> !flags[2]);
    a_r7_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (flags == '0) && !irq && !sig_queued);
    a_r6_sig_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && sig_queued) |=> flags[0]);
    a_r2_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != '0));
endmodule

bind gsr_unit gsr_unit_chk #(.N_EV(gsr_pkg::NUM_EV)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .rsp_valid  (rsp_valid),
    .irq        (irq),
    .ev_hsync   (ev_hsync),
    .ev_vsync   (ev_vsync),
    .csr_wr     (csr_wr),
    .soft_rst   (soft_rst),
    .ack        (ack),
    .sig_queued (sig_queued),
    .lane_lo    (lane[15:0]),
    .flags      (flags_q)
);

// File: tb/gsr_unit_tb.sv
// Bench: directed scenarios for the graphics status register unit.
module gsr_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic        req_ready;
    logic [12:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [7:0]  req_be = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        ev_signal = 0, ev_finish = 0, ev_hsync = 0, ev_vsync = 0, ev_rect_end = 0;
    logic        sq_valid = 0;
    logic [31:0] sq_data = '0, sq_mask = '0;
    logic        irq;
    int          n_run = 0, n_fail = 0;
    logic        done = 1'b0;
    logic [63:0] rd;

    localparam logic [31:0] BASE = 32'h551B_0000;

    always #10 clk = ~clk;

    gsr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ev_signal(ev_signal),
        .ev_finish(ev_finish), .ev_hsync(ev_hsync), .ev_vsync(ev_vsync),
        .ev_rect_end(ev_rect_end), .sq_valid(sq_valid), .sq_data(sq_data),
        .sq_mask(sq_mask), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [12:0] a, input logic [63:0] d,
                             input logic [7:0] b, input logic [4:0] ev);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_be = b;
        {ev_rect_end, ev_vsync, ev_hsync, ev_finish, ev_signal} = ev;
        @(negedge clk);
        req_valid = 0; req_write = 0; req_be = '0;
        {ev_rect_end, ev_vsync, ev_hsync, ev_finish, ev_signal} = '0;
    endtask

    task automatic pulse(input logic [4:0] ev);
        @(negedge clk);
        {ev_rect_end, ev_vsync, ev_hsync, ev_finish, ev_signal} = ev;
        @(negedge clk);
        {ev_rect_end, ev_vsync, ev_hsync, ev_finish, ev_signal} = '0;
    endtask

    task automatic bus_read(input logic [12:0] a, output logic [63:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        check("R9 rsp_valid", {63'b0, rsp_valid}, 64'd1);
        d = rsp_rdata;
    endtask

    task automatic queue(input logic [31:0] d, input logic [31:0] m);
        @(negedge clk);
        sq_valid = 1; sq_data = d; sq_mask = m;
        @(negedge clk);
        sq_valid = 0;
    endtask

    task automatic soft_reset();
        bus_write(13'h000, 64'h200, 8'h02, 5'b0);
    endtask

    task automatic t_reset_state();
        check("R11 irq", {63'b0, irq}, 0);
        check("R11 rsp_valid", {63'b0, rsp_valid}, 0);
        check("R11 req_ready", {63'b0, req_ready}, 1);
        bus_read(13'h000, rd); check("R11 csr", rd, {32'b0, BASE});
        bus_read(13'h080, rd); check("R11 sig id", rd, 0);
    endtask

    task automatic t_finish_gate();
        pulse(5'b00010);
        bus_read(13'h000, rd); check("R5 finish set", rd, {32'b0, BASE | 32'h2});
        bus_write(13'h000, 64'h2, 8'h01, 5'b0);
        bus_read(13'h000, rd); check("R5 finish cleared", rd, {32'b0, BASE});
        soft_reset();
        pulse(5'b00010);
        bus_read(13'h000, rd); check("R5 finish blocked after soft reset", rd, {32'b0, BASE});
        bus_write(13'h000, 64'h2, 8'h01, 5'b0);
        pulse(5'b00010);
        bus_read(13'h000, rd); check("R5 finish rearmed", rd, {32'b0, BASE | 32'h2});
    endtask

    task automatic t_masking();
        soft_reset();
        pulse(5'b00100);
        check("R1 masked after reset", {63'b0, irq}, 0);
        bus_write(13'h010, 64'h0, 8'hFF, 5'b0);
        check("R2 unmask pending", {63'b0, irq}, 1);
        bus_write(13'h010, 64'h1F00, 8'hFF, 5'b0);
        check("R1 remask", {63'b0, irq}, 0);
        bus_write(13'h010, 64'hFFFF, 8'h01, 5'b0);
        check("R8 lane1 disabled unmasks", {63'b0, irq}, 1);
        bus_write(13'h010, 64'hFFFF, 8'h02, 5'b0);
        check("R8 lane1 enabled masks", {63'b0, irq}, 0);
        bus_write(13'h010, 64'h0400, 8'hFF, 5'b0);
        check("R2 only hsync masked", {63'b0, irq}, 0);
        pulse(5'b01000);
        check("R3 unmasked vsync irq", {63'b0, irq}, 1);
    endtask

    task automatic t_w1c();
        soft_reset();
        pulse(5'b11100);
        bus_read(13'h000, rd); check("R3 flags set", rd, {32'b0, BASE | 32'h1C});
        bus_write(13'h000, 64'h0, 8'hFF, 5'b0);
        bus_read(13'h000, rd); check("R4 zero write no effect", rd, {32'b0, BASE | 32'h1C});
        bus_write(13'h000, 64'h4, 8'h02, 5'b0);
        bus_read(13'h000, rd); check("R8 disabled lane no clear", rd, {32'b0, BASE | 32'h1C});
        bus_write(13'h000, 64'h4, 8'h01, 5'b0);
        bus_read(13'h000, rd); check("R4 clear hsync", rd, {32'b0, BASE | 32'h18});
        bus_write(13'h000, 64'h8, 8'h01, 5'b01000);
        bus_read(13'h000, rd); check("R4 event wins clear", rd, {32'b0, BASE | 32'h18});
        bus_write(13'h000, 64'h18, 8'h01, 5'b0);
        bus_read(13'h000, rd); check("R4 clear rest", rd, {32'b0, BASE});
        pulse(5'b00100);
        bus_write(13'h000, 64'hFFFF_0100, 8'hFF, 5'b0);
        bus_read(13'h000, rd); check("R8 flush and rev/id ignored", rd, {32'b0, BASE | 32'h4});
    endtask

    task automatic t_signal();
        soft_reset();
        bus_write(13'h010, 64'h0, 8'hFF, 5'b0);
        queue(32'h1234_5678, 32'h0000_FFFF);
        pulse(5'b00001);
        check("R3 signal irq", {63'b0, irq}, 1);
        bus_write(13'h000, 64'h1, 8'h01, 5'b0);
        check("R6 ack keeps irq", {63'b0, irq}, 1);
        bus_read(13'h000, rd); check("R6 flag kept", rd, {32'b0, BASE | 32'h1});
        bus_read(13'h080, rd); check("R6 masked merge", rd, 64'h5678);
        bus_write(13'h000, 64'h1, 8'h01, 5'b0);
        check("R6 empty ack clears irq", {63'b0, irq}, 0);
        bus_read(13'h000, rd); check("R6 empty ack clears flag", rd, {32'b0, BASE});
        queue(32'h1111_0000, 32'hFFFF_0000);
        queue(32'hABCD_0000, 32'hFF00_0000);
        bus_write(13'h000, 64'h1, 8'h01, 5'b0);
        bus_read(13'h080, rd); check("R6 newest entry wins", rd, 64'hAB00_5678);
        bus_read(13'h000, rd); check("R6 queued ack sets flag", rd, {32'b0, BASE | 32'h1});
    endtask

    task automatic t_mirror();
        bus_read(13'h010, rd); check("R9 mask addr mirrors", rd, {32'b0, BASE | 32'h1});
        bus_read(13'h300, rd); check("R9 unmapped mirrors", rd, {32'b0, BASE | 32'h1});
        bus_read(13'h008, rd); check("R9 upper word zero", rd, 0);
        bus_read(13'h088, rd); check("R9 sig upper word zero", rd, 0);
        bus_read(13'h000, rd); check("R9 no read side effect", rd, {32'b0, BASE | 32'h1});
    endtask

    task automatic t_busdir_and_reset();
        bus_write(13'h040, 64'h1, 8'h01, 5'b0);
        bus_read(13'h000, rd); check("R10 dir and busy", rd, {32'b0, BASE | 32'h3001});
        bus_write(13'h040, 64'h0, 8'h01, 5'b0);
        bus_read(13'h000, rd); check("R10 busy stays", rd, {32'b0, BASE | 32'h1001});
        bus_write(13'h040, 64'h1, 8'h02, 5'b0);
        bus_read(13'h000, rd); check("R10 lane0 disabled", rd, {32'b0, BASE | 32'h1001});
        bus_write(13'h000, 64'h201, 8'h03, 5'b00100);
        bus_read(13'h000, rd); check("R7 soft reset clears", rd, {32'b0, BASE});
        bus_read(13'h080, rd); check("R7 sig id cleared", rd, 0);
        pulse(5'b00100);
        check("R7 mask restored", {63'b0, irq}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_finish_gate();
        t_masking();
        t_w1c();
        t_signal();
        t_mirror();
        t_busdir_and_reset();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule